// File: doc/BRIEF.md
# Attribute Controller Host Register Port

This block is the host-facing register interface of a display attribute controller. The host reaches every register through one write address. An internal toggle decides whether a given write selects a register or loads data into it. The first write after the toggle is back in its index state carries a 5-bit register number and a screen-output enable bit. The next write stores its data into the selected register. The toggle then returns to its index state.

The block holds sixteen palette entries and five control registers: mode control, border colour, colour plane enable, horizontal pel panning and colour select. All stored values are driven out in parallel for the pixel path.

Palette entries can be written only while screen output is off. A separate read port returns the selected register one cycle after a read strobe, and an index port shows the current selection at all times. A one-cycle strobe tells downstream logic that palette outputs must be recomputed.

Top module: `attr_regport`

## Requirements
- R1: When the toggle is in its index state (`phase_data`=0), a write stores `wr_data[4:0]` as the register index and moves the toggle to its data state (`phase_data`=1).
- R2: An index-state write with `wr_data[5]`=1 turns screen output on (`screen_en`=1). With `wr_data[5]`=0 it turns screen output off, which unlocks the palette.
- R3: A data-state write updates the register chosen by the stored index and returns the toggle to its index state.
- R4: A data-state write to an index from 0x00 to 0x0F updates that palette entry only while `screen_en`=0. Each entry keeps `wr_data[5:0]`; entry n is `palette[6n+5:6n]`.
- R5: `idx_data` always equals {2'b00, `screen_en`, index[4:0]}.
- R6: The pel panning register (index 0x13) keeps only `wr_data[3:0]` and reads back zero-extended.
- R7: Index 0x10 is mode control, 0x11 border colour, 0x12 plane enable and 0x14 colour select. Each of these stores all 8 bits and reads back unchanged. Palette entries read back zero-extended.
- R8: When `rd_en` is high at a clock edge, `rd_data` loads the value that the indexed register held before that edge, even if a write happens in the same cycle. `rd_data` holds between strobes, and reads never change the toggle.
- R9: Data writes to indices 0x15 to 0x1F change no register, and reading those indices returns 0x00.
- R10: `recalc_stb` is high for exactly the one cycle after a data write that changes mode control bit 7, plane enable bits 3:0 or any colour select bit. It is low after every other write.
- R11: A synchronous active-high `rst` puts the toggle in its index state and clears the index, `screen_en`, all registers, `rd_data` and `recalc_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the shared index/data address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Registered read data of the indexed register |
| idx_data | output | 8 | Index readback: screen enable and index |
| phase_data | output | 1 | Toggle state, 1 when the next write is data |
| screen_en | output | 1 | Screen output enabled (palette locked) |
| palette | output | 96 | Sixteen 6-bit palette entries, entry 0 in the low bits |
| mode_ctrl | output | 8 | Mode control register |
| border_col | output | 8 | Border colour register |
| plane_en | output | 8 | Colour plane enable register |
| pel_pan | output | 4 | Horizontal pel panning register |
| color_sel | output | 8 | Colour select register |
| recalc_stb | output | 1 | One-cycle palette recompute strobe |

## Verification
A data read and a data write can hit the same register in one cycle. The bench provokes this both in random traffic and in a directed case where `rd_en` is raised together with the data write that changes colour select. The result is judged correct only if `rd_data` shows the value from before the write, while the register output and `recalc_stb` show the new value in the next cycle. Palette writes are also issued with the screen turned on, and the bench checks that every palette entry stays unchanged.

// File: rtl/attr_pkg.sv
package attr_pkg;

    localparam int IDX_W  = 5;
    localparam int NPAL   = 16;
    localparam int PAL_W  = 6;
    localparam int DW     = 8;
    localparam int PAN_W  = 4;
    localparam int PAL_FLAT_W = NPAL * PAL_W;

    localparam logic [IDX_W-1:0] IX_MODE  = 5'h10;
    localparam logic [IDX_W-1:0] IX_BORD  = 5'h11;
    localparam logic [IDX_W-1:0] IX_PLANE = 5'h12;
    localparam logic [IDX_W-1:0] IX_PAN   = 5'h13;
    localparam logic [IDX_W-1:0] IX_CSEL  = 5'h14;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [DW-1:0]    mode;
        logic [DW-1:0]    bord;
        logic [DW-1:0]    plane;
        logic [PAN_W-1:0] pan;
        logic [DW-1:0]    csel;
    } ctl_regs_t;

    // True when an update touches a field that feeds palette composition
    function automatic logic recalc_needed(ctl_regs_t prev, ctl_regs_t next);
        return (prev.mode[7] != next.mode[7]) ||
               (prev.plane[3:0] != next.plane[3:0]) ||
               (prev.csel != next.csel);
    endfunction

endpackage

// File: rtl/attr_phase_ctl.sv
module attr_phase_ctl
    import attr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [5:0]       wr_lo,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             scr_en,
    output logic             data_wr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_INDEX;
            idx    <= '0;
            scr_en <= 1'b0;
        end else if (wr_en) begin
            if (phase == PH_INDEX) begin
                idx    <= wr_lo[IDX_W-1:0];
                scr_en <= wr_lo[5];
                phase  <= PH_DATA;
            end else begin
                phase  <= PH_INDEX;
            end
        end
    end

    assign data_wr = wr_en && (phase == PH_DATA);

endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
    import attr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  data_wr,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  scr_en,
    input  logic [DW-1:0]         wr_data,
    output logic [PAL_FLAT_W-1:0] pal_flat,
    output ctl_regs_t             ctl,
    output logic                  recalc_stb
);

    ctl_regs_t ctl_q, ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (data_wr) begin
            case (idx)
                IX_MODE:  ctl_d.mode  = wr_data;
                IX_BORD:  ctl_d.bord  = wr_data;
                IX_PLANE: ctl_d.plane = wr_data;
                IX_PAN:   ctl_d.pan   = wr_data[PAN_W-1:0];
                IX_CSEL:  ctl_d.csel  = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            recalc_stb <= 1'b0;
        end else begin
            ctl_q      <= ctl_d;
            recalc_stb <= recalc_needed(ctl_q, ctl_d);
        end
    end

    assign ctl = ctl_q;

    for (genvar g = 0; g < NPAL; g++) begin : g_pal
        logic [PAL_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (data_wr && !scr_en && idx == IDX_W'(g))
                q <= wr_data[PAL_W-1:0];
        end
        assign pal_flat[g*PAL_W +: PAL_W] = q;
    end

endmodule

// File: rtl/attr_rdmux.sv
module attr_rdmux
    import attr_pkg::*;
(
    input  logic [IDX_W-1:0]      idx,
    input  logic [PAL_FLAT_W-1:0] pal_flat,
    input  ctl_regs_t             ctl,
    output logic [DW-1:0]         rd_val
);

    always_comb begin
        rd_val = '0;
        if (idx < IDX_W'(NPAL)) begin
            rd_val = DW'(pal_flat[idx[3:0]*PAL_W +: PAL_W]);
        end else begin
            case (idx)
                IX_MODE:  rd_val = ctl.mode;
                IX_BORD:  rd_val = ctl.bord;
                IX_PLANE: rd_val = ctl.plane;
                IX_PAN:   rd_val = DW'(ctl.pan);
                IX_CSEL:  rd_val = ctl.csel;
                default:  rd_val = '0;
            endcase
        end
    end

endmodule

// File: rtl/attr_regport.sv
module attr_regport
    import attr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [DW-1:0]         wr_data,
    input  logic                  rd_en,
    output logic [DW-1:0]         rd_data,
    output logic [DW-1:0]         idx_data,
    output logic                  phase_data,
    output logic                  screen_en,
    output logic [PAL_FLAT_W-1:0] palette,
    output logic [DW-1:0]         mode_ctrl,
    output logic [DW-1:0]         border_col,
    output logic [DW-1:0]         plane_en,
    output logic [PAN_W-1:0]      pel_pan,
    output logic [DW-1:0]         color_sel,
    output logic                  recalc_stb
);

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             scr_en;
    logic             data_wr;
    ctl_regs_t        ctl;
    logic [DW-1:0]    rd_val;

    attr_phase_ctl u_phase (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_lo   (wr_data[5:0]),
        .phase   (phase),
        .idx     (idx),
        .scr_en  (scr_en),
        .data_wr (data_wr)
    );

    attr_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .data_wr    (data_wr),
        .idx        (idx),
        .scr_en     (scr_en),
        .wr_data    (wr_data),
        .pal_flat   (palette),
        .ctl        (ctl),
        .recalc_stb (recalc_stb)
    );

    attr_rdmux u_rdmux (
        .idx      (idx),
        .pal_flat (palette),
        .ctl      (ctl),
        .rd_val   (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_val;
    end

    assign idx_data   = {2'b00, scr_en, idx};
    assign phase_data = (phase == PH_DATA);
    assign screen_en  = scr_en;
    assign mode_ctrl  = ctl.mode;
    assign border_col = ctl.bord;
    assign plane_en   = ctl.plane;
    assign pel_pan    = ctl.pan;
    assign color_sel  = ctl.csel;

endmodule

// File: rtl/attr_regport_chk.sv
module attr_regport_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic        rd_en,
    input logic [7:0]  rd_data,
    input logic [7:0]  idx_data,
    input logic        phase_data,
    input logic        screen_en,
    input logic [95:0] palette,
    input logic [7:0]  mode_ctrl,
    input logic [7:0]  border_col,
    input logic [7:0]  plane_en,
    input logic [3:0]  pel_pan,
    input logic [7:0]  color_sel,
    input logic        recalc_stb
);

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (phase_data != $past(phase_data)));  // R1

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(phase_data));  // R8

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !phase_data) |=> (idx_data[5:0] == $past(wr_data[5:0])));  // R2

    AST_PAL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && phase_data && screen_en && idx_data[4] == 1'b0) |=> $stable(palette));  // R4

    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && phase_data && idx_data[4:0] > 5'h14) |=>
        ($stable(mode_ctrl) && $stable(border_col) && $stable(plane_en) &&
         $stable(pel_pan) && $stable(color_sel) && $stable(palette)));  // R9

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        recalc_stb |-> ($past(wr_en) && $past(phase_data)));  // R10

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));  // R8

endmodule

bind attr_regport attr_regport_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .idx_data   (idx_data),
    .phase_data (phase_data),
    .screen_en  (screen_en),
    .palette    (palette),
    .mode_ctrl  (mode_ctrl),
    .border_col (border_col),
    .plane_en   (plane_en),
    .pel_pan    (pel_pan),
    .color_sel  (color_sel),
    .recalc_stb (recalc_stb)
);

// File: tb/sim_attr_regport.sv
module sim_attr_regport;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic [7:0]  idx_data;
    logic        phase_data;
    logic        screen_en;
    logic [95:0] palette;
    logic [7:0]  mode_ctrl, border_col, plane_en, color_sel;
    logic [3:0]  pel_pan;
    logic        recalc_stb;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Reference model state
    bit         m_ph;
    logic [4:0] m_ix;
    bit         m_scr;
    logic [5:0] m_pal [16];
    logic [7:0] m_mode, m_bord, m_pen, m_cs, m_rd;
    logic [3:0] m_pan;
    bit         m_stb;

    always #10 clk = ~clk;

    attr_regport u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .idx_data(idx_data), .phase_data(phase_data),
        .screen_en(screen_en), .palette(palette), .mode_ctrl(mode_ctrl),
        .border_col(border_col), .plane_en(plane_en), .pel_pan(pel_pan),
        .color_sel(color_sel), .recalc_stb(recalc_stb)
    );

    function automatic logic [7:0] exp_read(logic [4:0] ix);
        if (ix < 5'h10) return {2'b00, m_pal[ix[3:0]]};
        case (ix)
            5'h10: return m_mode;
            5'h11: return m_bord;
            5'h12: return m_pen;
            5'h13: return {4'h0, m_pan};
            5'h14: return m_cs;
            default: return 8'h00;  // R9 unknown index reads zero
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_ix = '0; m_scr = 0; m_mode = '0; m_bord = '0;
        m_pen = '0; m_cs = '0; m_pan = '0; m_stb = 0; m_rd = '0;
        for (int i = 0; i < 16; i++) m_pal[i] = '0;
    endtask

    task automatic compare_all();
        chk("R1/R3 phase", {31'b0, phase_data}, {31'b0, m_ph});
        chk("R2 screen_en", {31'b0, screen_en}, {31'b0, m_scr});
        chk("R5 idx_data", {24'b0, idx_data}, {24'b0, 2'b00, m_scr, m_ix});
        for (int i = 0; i < 16; i++)
            chk("R4 palette", {26'b0, palette[i*6 +: 6]}, {26'b0, m_pal[i]});
        chk("R7 mode", {24'b0, mode_ctrl}, {24'b0, m_mode});
        chk("R7 border", {24'b0, border_col}, {24'b0, m_bord});
        chk("R7 plane", {24'b0, plane_en}, {24'b0, m_pen});
        chk("R6 pan", {28'b0, pel_pan}, {28'b0, m_pan});
        chk("R7 csel", {24'b0, color_sel}, {24'b0, m_cs});
        chk("R10 strobe", {31'b0, recalc_stb}, {31'b0, m_stb});
        chk("R8 rd_data", {24'b0, rd_data}, {24'b0, m_rd});
    endtask

    // One bus cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(bit w, logic [7:0] d, bit r);
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        if (r) m_rd = exp_read(m_ix);   // R8 pre-write value
        m_stb = 0;
        if (w) begin
            if (!m_ph) begin            // R1, R2
                m_ix = d[4:0]; m_scr = d[5]; m_ph = 1;
            end else begin              // R3
                m_ph = 0;
                if (m_ix < 5'h10) begin
                    if (!m_scr) m_pal[m_ix[3:0]] = d[5:0];  // R4
                end else case (m_ix)
                    5'h10: begin m_stb = (m_mode[7] != d[7]); m_mode = d; end
                    5'h11: m_bord = d;
                    5'h12: begin m_stb = (m_pen[3:0] != d[3:0]); m_pen = d; end
                    5'h13: m_pan = d[3:0];  // R6
                    5'h14: begin m_stb = (m_cs != d); m_cs = d; end
                    default: ;  // R9 ignored
                endcase
            end
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        compare_all();
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        if (!done) $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; wr_en = 0; wr_data = '0; rd_en = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare_all();  // R11 reset state

        // R7/R10: mode bit 7 change strobes, same value does not
        step(1, 8'h10, 0); step(1, 8'h80, 0);
        step(1, 8'h10, 0); step(1, 8'h80, 0);
        // R6: panning keeps low nibble
        step(1, 8'h13, 0); step(1, 8'hFF, 1);
        step(0, 8'h00, 1);
        // R4: palette locked with screen on, open with screen off
        step(1, 8'h25, 0); step(1, 8'h3F, 0);
        step(1, 8'h05, 0); step(1, 8'hEA, 0);
        // R9: unknown index ignored and reads zero
        step(1, 8'h17, 0); step(1, 8'hFF, 1);
        chk("R9 unknown read", {24'b0, rd_data}, 32'h0);
        // R8: read and write of colour select in the same cycle
        step(1, 8'h14, 0); step(1, 8'h55, 1);
        chk("R8 old value read", {24'b0, rd_data}, 32'h0);
        step(0, 8'h00, 1);
        // R10: plane enable upper bits only, no strobe
        step(1, 8'h12, 0); step(1, 8'hF0, 0);
        step(1, 8'h12, 0); step(1, 8'h03, 0);

        for (int n = 0; n < 3000; n++) begin
            logic [7:0] d;
            bit w, r;
            d = 8'($urandom);
            w = ($urandom % 4) != 0;
            r = ($urandom % 3) == 0;
            if (!m_ph) d[4:0] = 5'($urandom % 26);
            step(w, d, r);
        end

        // R11: reset mid-operation
        step(1, 8'h3A, 0);
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        compare_all();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule